// File: doc/BRIEF.md
# Programmable Wait-State Generator

This block stretches external accesses by holding a ready line low for a programmed number of clock cycles. There are three address spaces: program, data and I/O. Each space is 64K words, and the top two address bits split it into four 16K-word regions. Each region has its own 2-bit wait code. Software writes the codes through a small write-only register port. No strap or pin sets a count.

A per-space register bit changes the meaning of code 3 from three waits to seven. That gives each region the choice of 0, 1, 2, 3 or 7 waits.

A second mode is switched on by a bit in a separate register. In that mode the block ignores the region codes. It applies one 3-bit count (0 to 7) per space to every address in that space.

An access is started by a strobe together with a space select and a 16-bit address. Ready responds in the same cycle as the strobe. It stays low for exactly the programmed count and then comes back high for one cycle. A new access is taken only after ready has been returned for the previous one.

Top module: `ws_gen`

## Requirements
- R1: After a synchronous reset, every region code is 0, the long-code bits are 0, single-count mode is off, and `rdy` is high. Every access then completes with zero waits.
- R2: In region mode, the wait code for an access comes from the 2-bit field at bits [2q+1:2q] of the register at `cfg_addr` equal to the space number. Here q is `acc_addr[15:14]`. The space numbers are 0 = program, 1 = data and 2 = I/O.
- R3: Codes 0, 1 and 2 give that many waits. Code 3 gives 3 waits when bit 8 of that space's register is 0, and 7 waits when it is 1.
- R4: When bit 15 of the register at `cfg_addr` 3 is set, the wait count is a single count per space, and the address is ignored. The program count is in bits [2:0], the data count in bits [6:4] and the I/O count in bits [10:8].
- R5: For a count N greater than 0, `rdy` is low in the strobe cycle and the N-1 cycles that follow. It is then high for one cycle.
- R6: With a count of 0, `rdy` stays high, and a strobe is accepted in every cycle.
- R7: A strobe seen while an access is waiting, or in its ready-return cycle, is ignored. It neither stretches the current access nor starts a new one.
- R8: A register write takes effect for a strobe in the next cycle. The count of an access that has already started is not changed.
- R9: Space select 3 is not a valid space and always gives zero waits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write enable |
| cfg_addr | input | 2 | Register select: 0..2 space registers, 3 single-count register |
| cfg_wdata | input | 16 | Register write data |
| acc_strobe | input | 1 | Access request |
| acc_space | input | 2 | Address space of the access |
| acc_addr | input | 16 | Word address of the access |
| rdy | output | 1 | Ready, low while the access waits |

## Verification
A wrong region lookup or a wrong code decode shows up at once as a wrong number of low `rdy` cycles. This is why the bench sweeps every space, region, code and long-code setting, and every single-count value. A counter that is off by one, or a ready-return state that lasts too long, shows at the end of the low window. A machine that relaunches on a held strobe drops `rdy` in the cycle after the return, which the bench samples. A register that loads late, or that changes an access already in flight, is seen in the first access that follows the write.

// File: rtl/ws_pkg.sv
package ws_pkg;

    localparam int ADDR_W      = 16;
    localparam int DATA_W      = 16;
    localparam int REGION_BITS = 2;
    localparam int NUM_REGIONS = 1 << REGION_BITS;
    localparam int NUM_SPACES  = 3;
    localparam int SPACE_W     = 2;
    localparam int CODE_W      = 2;
    localparam int CNT_W       = 3;
    localparam int CFG_ADDR_W  = 2;

    localparam int LONG_BIT    = NUM_REGIONS * CODE_W;
    localparam int FLAT_STRIDE = 4;
    localparam int FLAT_EN_BIT = DATA_W - 1;
    localparam logic [CFG_ADDR_W-1:0] FLAT_REG_ADDR = CFG_ADDR_W'(NUM_SPACES);

    localparam logic [CNT_W-1:0] SHORT_TOP_WAITS = CNT_W'(3);
    localparam logic [CNT_W-1:0] LONG_TOP_WAITS  = CNT_W'(7);

    typedef enum logic [SPACE_W-1:0] {
        SPACE_PROG = 2'd0,
        SPACE_DATA = 2'd1,
        SPACE_IO   = 2'd2,
        SPACE_RSVD = 2'd3
    } space_e;

    typedef struct packed {
        logic                                long_top;
        logic [NUM_REGIONS-1:0][CODE_W-1:0] codes;
    } space_cfg_t;

    typedef struct packed {
        logic                               flat_en;
        logic [NUM_SPACES-1:0][CNT_W-1:0]   counts;
    } flat_cfg_t;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_HOLD    = 2'd1,
        ST_RELEASE = 2'd2
    } ws_state_e;

    function automatic logic [CNT_W-1:0] code_to_waits(
        input logic [CODE_W-1:0] code,
        input logic              long_top
    );
        logic [CNT_W-1:0] w;
        unique case (code)
            2'd0:    w = CNT_W'(0);
            2'd1:    w = CNT_W'(1);
            2'd2:    w = CNT_W'(2);
            default: w = long_top ? LONG_TOP_WAITS : SHORT_TOP_WAITS;
        endcase
        return w;
    endfunction

endpackage

// File: rtl/ws_cfg_regs.sv
module ws_cfg_regs
    import ws_pkg::*;
(
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              we,
    input  logic [CFG_ADDR_W-1:0]             addr,
    input  logic [DATA_W-1:0]                 wdata,
    output space_cfg_t [NUM_SPACES-1:0]       space_cfg_o,
    output flat_cfg_t                         flat_cfg_o
);

    space_cfg_t [NUM_SPACES-1:0] space_q;
    flat_cfg_t                   flat_q;

    for (genvar s = 0; s < NUM_SPACES; s++) begin : g_space_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                space_q[s] <= '0;
            end else if (we && addr == CFG_ADDR_W'(s)) begin
                space_q[s].long_top <= wdata[LONG_BIT];
                for (int q = 0; q < NUM_REGIONS; q++) begin
                    space_q[s].codes[q] <= wdata[q*CODE_W +: CODE_W];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flat_q <= '0;
        end else if (we && addr == FLAT_REG_ADDR) begin
            flat_q.flat_en <= wdata[FLAT_EN_BIT];
            for (int s = 0; s < NUM_SPACES; s++) begin
                flat_q.counts[s] <= wdata[s*FLAT_STRIDE +: CNT_W];
            end
        end
    end

    assign space_cfg_o = space_q;
    assign flat_cfg_o  = flat_q;

endmodule

// File: rtl/ws_count_sel.sv
module ws_count_sel
    import ws_pkg::*;
(
    input  space_cfg_t [NUM_SPACES-1:0] space_cfg_i,
    input  flat_cfg_t                   flat_cfg_i,
    input  logic [SPACE_W-1:0]          space_i,
    input  logic [REGION_BITS-1:0]      region_i,
    output logic [CNT_W-1:0]            waits_o
);

    logic                   space_ok;
    space_cfg_t             sel_cfg;
    logic [CNT_W-1:0]       region_waits;
    logic [CNT_W-1:0]       flat_waits;

    assign space_ok = (int'(space_i) < NUM_SPACES);

    always_comb begin
        sel_cfg    = '0;
        flat_waits = '0;
        for (int s = 0; s < NUM_SPACES; s++) begin
            if (space_i == SPACE_W'(s)) begin
                sel_cfg    = space_cfg_i[s];
                flat_waits = flat_cfg_i.counts[s];
            end
        end
    end

    assign region_waits = code_to_waits(sel_cfg.codes[region_i], sel_cfg.long_top);

    always_comb begin
        if (!space_ok) begin
            waits_o = '0;
        end else if (flat_cfg_i.flat_en) begin
            waits_o = flat_waits;
        end else begin
            waits_o = region_waits;
        end
    end

endmodule

// File: rtl/ws_ready_fsm.sv
module ws_ready_fsm
    import ws_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             strobe_i,
    input  logic [CNT_W-1:0] waits_i,
    output logic             rdy_o,
    output logic             busy_o
);

    ws_state_e        state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        rdy_o   = 1'b1;
        unique case (state_q)
            ST_IDLE: begin
                if (strobe_i && waits_i != '0) begin
                    rdy_o   = 1'b0;
                    cnt_d   = waits_i - 1'b1;
                    state_d = (waits_i == CNT_W'(1)) ? ST_RELEASE : ST_HOLD;
                end
            end
            ST_HOLD: begin
                rdy_o = 1'b0;
                cnt_d = cnt_q - 1'b1;
                if (cnt_q == CNT_W'(1)) begin
                    state_d = ST_RELEASE;
                end
            end
            ST_RELEASE: begin
                rdy_o   = 1'b1;
                state_d = ST_IDLE;
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    assign busy_o = (state_q != ST_IDLE);

    assert_hold_steps_R5: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_HOLD && cnt_q > CNT_W'(1)) |=>
            (state_q == ST_HOLD && cnt_q == $past(cnt_q) - 1'b1));

    assert_hold_ends_R5: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_HOLD && cnt_q == CNT_W'(1)) |=> (state_q == ST_RELEASE));

    assert_release_single_R7: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_RELEASE) |=> (state_q == ST_IDLE));

endmodule

// File: rtl/ws_gen.sv
module ws_gen
    import ws_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   cfg_we,
    input  logic [CFG_ADDR_W-1:0]  cfg_addr,
    input  logic [DATA_W-1:0]      cfg_wdata,
    input  logic                   acc_strobe,
    input  logic [SPACE_W-1:0]     acc_space,
    input  logic [ADDR_W-1:0]      acc_addr,
    output logic                   rdy
);

    space_cfg_t [NUM_SPACES-1:0] space_cfg;
    flat_cfg_t                   flat_cfg;
    logic [CNT_W-1:0]            waits;
    logic                        busy;
    logic [REGION_BITS-1:0]      region;

    assign region = acc_addr[ADDR_W-1 -: REGION_BITS];

    ws_cfg_regs u_regs (
        .clk         (clk),
        .rst         (rst),
        .we          (cfg_we),
        .addr        (cfg_addr),
        .wdata       (cfg_wdata),
        .space_cfg_o (space_cfg),
        .flat_cfg_o  (flat_cfg)
    );

    ws_count_sel u_sel (
        .space_cfg_i (space_cfg),
        .flat_cfg_i  (flat_cfg),
        .space_i     (acc_space),
        .region_i    (region),
        .waits_o     (waits)
    );

    ws_ready_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .strobe_i (acc_strobe),
        .waits_i  (waits),
        .rdy_o    (rdy),
        .busy_o   (busy)
    );

    assert_zero_wait_ready_R6: assert property (@(posedge clk) disable iff (rst)
        (!busy && acc_strobe && waits == '0) |-> rdy);

    assert_region_set_R3: assert property (@(posedge clk) disable iff (rst)
        (!flat_cfg.flat_en) |->
            (waits <= SHORT_TOP_WAITS || waits == LONG_TOP_WAITS));

    assert_reserved_space_R9: assert property (@(posedge clk) disable iff (rst)
        (acc_space == SPACE_RSVD) |-> (waits == '0));

    assert_flat_load_R8: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && cfg_addr == FLAT_REG_ADDR) |=>
            (flat_cfg.flat_en == $past(cfg_wdata[FLAT_EN_BIT])));

    assert_strobe_in_wait_R7: assert property (@(posedge clk) disable iff (rst)
        (busy && acc_strobe) |=> (busy == ($past(rdy) == 1'b0)));

endmodule

// File: tb/test_ws_gen.sv
`timescale 1ns/1ps
module test_ws_gen;

    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_we;
    logic [1:0]  cfg_addr;
    logic [15:0] cfg_wdata;
    logic        acc_strobe;
    logic [1:0]  acc_space;
    logic [15:0] acc_addr;
    logic        rdy;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;

    always #4 clk = ~clk;

    ws_gen i_ws_gen (
        .clk        (clk),
        .rst        (rst),
        .cfg_we     (cfg_we),
        .cfg_addr   (cfg_addr),
        .cfg_wdata  (cfg_wdata),
        .acc_strobe (acc_strobe),
        .acc_space  (acc_space),
        .acc_addr   (acc_addr),
        .rdy        (rdy)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles, expected under 100000", cycles);
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Holds the strobe through the whole access; counts low cycles of rdy.
    // wr: write (wa, wd) in the strobe cycle. nosync: start at the current negedge.
    task automatic do_access(input logic [1:0] sp, input logic [15:0] ad,
                             input bit nosync, input bit wr,
                             input logic [1:0] wa, input logic [15:0] wd,
                             output int lows, output bit relaunch);
        if (!nosync) @(negedge clk);
        acc_space = sp; acc_addr = ad; acc_strobe = 1'b1;
        if (wr) begin
            cfg_we = 1'b1; cfg_addr = wa; cfg_wdata = wd;
        end
        lows = 0;
        for (int k = 0; k < 12; k++) begin
            #1;
            if (rdy) break;
            lows++;
            @(negedge clk);
            cfg_we = 1'b0;
        end
        @(negedge clk);
        cfg_we = 1'b0;
        acc_strobe = 1'b0;
        #1;
        relaunch = !rdy;
    endtask

    function automatic int exp_waits(input int code, input int longb);
        if (code < 3) return code;
        return longb ? 7 : 3;
    endfunction

    function automatic logic [15:0] space_word(input int r, input int c_hit, input int c_other, input int longb);
        logic [15:0] w = '0;
        for (int q = 0; q < 4; q++) begin
            w[2*q +: 2] = 2'((q == r) ? c_hit : c_other);
        end
        w[8] = 1'(longb);
        return w;
    endfunction

    initial begin
        int  lows;
        bit  rl;
        rst = 1'b1; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
        acc_strobe = 1'b0; acc_space = '0; acc_addr = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        check(rdy == 1'b1, "R1 ready after reset", int'(rdy), 1);

        // R1: defaults give zero waits in every space and region
        for (int s = 0; s < 3; s++) begin
            for (int r = 0; r < 4; r++) begin
                do_access(2'(s), 16'(r << 14), 1'b0, 1'b0, 2'd0, 16'd0, lows, rl);
                check(lows == 0, "R1 default zero waits", lows, 0);
            end
        end

        // R2 R3 R5 R7: sweep space, region, code, long bit
        for (int s = 0; s < 3; s++) begin
            for (int r = 0; r < 4; r++) begin
                for (int c = 0; c < 4; c++) begin
                    for (int l = 0; l < 2; l++) begin
                        for (int o = 0; o < 3; o++) begin
                            if (o == s)
                                cfg_write(2'(o), space_word(r, c, (c + 1) % 4, l));
                            else
                                cfg_write(2'(o), space_word(r, (c + 2) % 4, (c + 2) % 4, 1 - l));
                        end
                        do_access(2'(s), 16'((r << 14) | ((c * 1237 + s * 31 + l) & 16'h3FFF)),
                                  1'b0, 1'b0, 2'd0, 16'd0, lows, rl);
                        check(lows == exp_waits(c, l), "R2/R3/R5 region wait count", lows, exp_waits(c, l));
                        check(!rl, "R7 held strobe not relaunched", int'(rl), 0);
                    end
                end
            end
        end

        // R4: single-count mode overrides region codes; address ignored
        for (int o = 0; o < 3; o++) cfg_write(2'(o), space_word(0, 1, 2, 1));
        for (int s = 0; s < 3; s++) begin
            for (int n = 0; n < 8; n++) begin
                logic [15:0] fw = 16'h8000;
                for (int o = 0; o < 3; o++) fw[4*o +: 3] = 3'((o == s) ? n : 7 - n);
                cfg_write(2'd3, fw);
                for (int r = 0; r < 4; r++) begin
                    do_access(2'(s), 16'((r << 14) | (n * 97)), 1'b0, 1'b0, 2'd0, 16'd0, lows, rl);
                    check(lows == n, "R4 single count per space", lows, n);
                end
            end
        end

        // R9: reserved space gives zero waits in both modes
        do_access(2'd3, 16'hC000, 1'b0, 1'b0, 2'd0, 16'd0, lows, rl);
        check(lows == 0, "R9 reserved space single-count mode", lows, 0);
        cfg_write(2'd3, 16'h0000);
        do_access(2'd3, 16'h4000, 1'b0, 1'b0, 2'd0, 16'd0, lows, rl);
        check(lows == 0, "R9 reserved space region mode", lows, 0);
        do_access(2'd0, 16'h0000, 1'b0, 1'b0, 2'd0, 16'd0, lows, rl);
        check(lows == 1, "R4 region mode restored", lows, 1);

        // R6: zero waits, strobe held across back-to-back accesses
        cfg_write(2'd1, 16'h0000);
        @(negedge clk);
        acc_strobe = 1'b1; acc_space = 2'd1;
        for (int k = 0; k < 4; k++) begin
            acc_addr = 16'(k << 14);
            #1;
            check(rdy == 1'b1, "R6 zero-wait back to back", int'(rdy), 1);
            @(negedge clk);
        end
        acc_strobe = 1'b0;

        // R8: write during access leaves it unchanged; next access sees new value
        cfg_write(2'd1, space_word(1, 2, 0, 0));
        do_access(2'd1, 16'h4000, 1'b0, 1'b1, 2'd1, space_word(1, 3, 0, 1), lows, rl);
        check(lows == 2, "R8 in-flight access keeps count", lows, 2);
        do_access(2'd1, 16'h4000, 1'b0, 1'b0, 2'd0, 16'd0, lows, rl);
        check(lows == 7, "R8 new count after write", lows, 7);
        // R8: write, then strobe in the very next cycle
        cfg_write(2'd1, space_word(1, 1, 0, 0));
        do_access(2'd1, 16'h4000, 1'b1, 1'b0, 2'd0, 16'd0, lows, rl);
        check(lows == 1, "R8 write visible next cycle", lows, 1);

        // R1: reset clears configuration
        cfg_write(2'd2, space_word(0, 3, 3, 1));
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        do_access(2'd2, 16'h0000, 1'b0, 1'b0, 2'd0, 16'd0, lows, rl);
        check(lows == 0, "R1 reset clears codes", lows, 0);

        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule